// File: doc/BRIEF.md
# Fetch Address Sequencer with Branch Delay Slot

This block produces the instruction fetch address for a five-stage 32-bit pipeline in which branches and jumps are decided in the register-read stage. It holds two registers. The first is the address being fetched now. The second is the return address (fetch address + 4) of the instruction that currently sits in the register-read stage.

Each cycle, a 3-bit source select picks the next fetch address from one of these:
- the sequential successor
- a conditional branch target, taken on a zero or on a non-zero bypassed operand
- a jump through the bypassed register operand
- an absolute jump built from the instruction's 26-bit field
- two fixed trap vectors

The instruction fetched while a branch is being decided is the delay slot. It always proceeds, so the block never flushes anything.

A low advance enable freezes both registers so that the front end can wait for a load result. A synchronous reset loads the reset vector ahead of every other input.

Top module: `nextpc_unit`

## Requirements
- R1: With rst high at a clock edge, pc_fetch becomes 0x80000000 and rs_pc_plus4 becomes 0x80000000, whatever adv_en, pc_sel and the data inputs are.
- R2: pc_sel values 0 and 7 make pc_next equal pc_fetch + 4.
- R3: pc_sel = 1 (branch if zero) makes pc_next equal rs_pc_plus4 + (sign-extended rs_instr[15:0] shifted left by 2) when rs_opnd is zero, and pc_fetch + 4 otherwise.
- R4: pc_sel = 2 (branch if non-zero) makes pc_next equal the same branch target when rs_opnd is non-zero, and pc_fetch + 4 otherwise.
- R5: pc_sel = 3 makes pc_next equal rs_opnd, which is the bypassed operand.
- R6: pc_sel = 4 builds pc_next as follows: bits 31:29 from rs_pc_plus4[31:29], bit 28 zero, bits 27:2 from rs_instr[25:0], and bits 1:0 zero.
- R7: pc_sel = 5 makes pc_next 0x80000040, and pc_sel = 6 makes it 0x80000080.
- R8: While adv_en is low and rst is low, pc_fetch and rs_pc_plus4 keep their values at every clock edge, for any pc_sel and data inputs.
- R9: With adv_en high and rst low, a clock edge loads pc_next into pc_fetch and loads the old pc_fetch + 4 into rs_pc_plus4. The address after a taken branch is therefore still the delay slot, and the target follows it.
- R10: opnd_zero is high exactly when rs_opnd is all zeros. pc_next depends on neither adv_en nor rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance enable; low freezes the fetch and register-stage addresses |
| pc_sel | input | 3 | Next-address source select (0..6 used, 7 sequential) |
| rs_instr | input | 32 | Instruction in the register-read stage |
| rs_opnd | input | 32 | Bypassed first register operand |
| opnd_zero | output | 1 | Zero test of rs_opnd |
| pc_fetch | output | 32 | Current fetch address |
| rs_pc_plus4 | output | 32 | Return address of the register-stage instruction |
| pc_next | output | 32 | Selected next fetch address |

## Verification
The bench drives negative and positive branch offsets, including the most negative immediate, so that a design which zero-extends the immediate or forgets the two-bit shift sends the fetch to the wrong address. Operands of zero, one and all ones probe both branch senses; a design with a swapped condition or an inverted zero test would take the wrong path. Absolute jumps are issued while the fetch address has its top bits set, which exposes a design that takes the upper bits from the wrong register or misplaces the 26-bit field. Stalls are applied under every select, and a reset is applied during a stall; a design that lets a select leak through a frozen front end, or lets the stall block the reset, would lose the delay slot or start from the wrong vector.

// File: rtl/nextpc_unit.sv
module nextpc_unit #(
  parameter logic [31:0] RESET_VEC = 32'h8000_0000,
  parameter logic [31:0] TRAP_VEC  = 32'h8000_0040,
  parameter logic [31:0] IRQ_VEC   = 32'h8000_0080
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adv_en,
  input  logic [2:0]  pc_sel,
  input  logic [31:0] rs_instr,
  input  logic [31:0] rs_opnd,
  output logic        opnd_zero,
  output logic [31:0] pc_fetch,
  output logic [31:0] rs_pc_plus4,
  output logic [31:0] pc_next
);

  localparam logic [2:0] SEL_SEQ  = 3'd0;
  localparam logic [2:0] SEL_BZ   = 3'd1;
  localparam logic [2:0] SEL_BNZ  = 3'd2;
  localparam logic [2:0] SEL_JREG = 3'd3;
  localparam logic [2:0] SEL_JABS = 3'd4;
  localparam logic [2:0] SEL_TRAP = 3'd5;
  localparam logic [2:0] SEL_IRQ  = 3'd6;

  logic [31:0] pc_q, rs4_q;
  logic [31:0] seq_pc, br_tgt, abs_tgt;

  assign opnd_zero = (rs_opnd == 32'd0);
  assign seq_pc    = pc_q + 32'd4;
  assign br_tgt    = rs4_q + {{14{rs_instr[15]}}, rs_instr[15:0], 2'b00};
  assign abs_tgt   = {rs4_q[31:29], 1'b0, rs_instr[25:0], 2'b00};

  always_comb begin
    case (pc_sel)
      SEL_BZ:   pc_next = opnd_zero ? br_tgt : seq_pc;
      SEL_BNZ:  pc_next = opnd_zero ? seq_pc : br_tgt;
      SEL_JREG: pc_next = rs_opnd;
      SEL_JABS: pc_next = abs_tgt;
      SEL_TRAP: pc_next = TRAP_VEC;
      SEL_IRQ:  pc_next = IRQ_VEC;
      default:  pc_next = seq_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_VEC;
      rs4_q <= RESET_VEC;
    end else if (adv_en) begin
      pc_q  <= pc_next;
      rs4_q <= seq_pc;
    end
  end

  assign pc_fetch    = pc_q;
  assign rs_pc_plus4 = rs4_q;

  p_reset_vec_r1: assert property (@(posedge clk)
    rst |=> (pc_fetch == RESET_VEC && rs_pc_plus4 == RESET_VEC));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (adv_en && (pc_sel == SEL_SEQ || pc_sel == 3'd7)) |=> pc_fetch == $past(pc_fetch) + 32'd4);

  p_jreg_r5: assert property (@(posedge clk) disable iff (rst)
    (adv_en && pc_sel == SEL_JREG) |=> pc_fetch == $past(rs_opnd));

  p_vectors_r7: assert property (@(posedge clk) disable iff (rst)
    (adv_en && pc_sel == SEL_TRAP) |=> pc_fetch == TRAP_VEC);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> ($stable(pc_fetch) && $stable(rs_pc_plus4)));

  p_delay_slot_r9: assert property (@(posedge clk) disable iff (rst)
    adv_en |=> rs_pc_plus4 == $past(pc_fetch) + 32'd4);

  p_zero_flag_r10: assert property (@(posedge clk)
    opnd_zero == ($countones(rs_opnd) == 0));

endmodule

// File: tb/nextpc_unit_tb_top.sv
module nextpc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst, adv_en;
  logic [2:0]  pc_sel;
  logic [31:0] rs_instr, rs_opnd;
  logic        opnd_zero;
  logic [31:0] pc_fetch, rs_pc_plus4, pc_next;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  longint m_pc, m_rs4;

  always #2 clk = ~clk;

  nextpc_unit dut_i (
    .clk(clk), .rst(rst), .adv_en(adv_en), .pc_sel(pc_sel),
    .rs_instr(rs_instr), .rs_opnd(rs_opnd), .opnd_zero(opnd_zero),
    .pc_fetch(pc_fetch), .rs_pc_plus4(rs_pc_plus4), .pc_next(pc_next)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if ((act & 64'hFFFF_FFFF) != (exp & 64'hFFFF_FFFF)) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act[31:0], exp[31:0]);
    end
  endtask

  function automatic string tag_of(int sel);
    case (sel)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5, 6: return "R7";
      default: return "R2";
    endcase
  endfunction

  function automatic longint model_next(int sel, longint ins, longint op, longint pc, longint rs4);
    longint off, imm;
    imm = ins % 65536;
    off = (imm >= 32768) ? (imm - 65536) * 4 : imm * 4;
    case (sel)
      1: return (op == 0) ? (rs4 + off) % 64'h1_0000_0000 : (pc + 4) % 64'h1_0000_0000;
      2: return (op != 0) ? (rs4 + off) % 64'h1_0000_0000 : (pc + 4) % 64'h1_0000_0000;
      3: return op;
      4: return (rs4 / 64'h2000_0000) * 64'h2000_0000 + (ins % 64'h400_0000) * 4;
      5: return 64'h8000_0040;
      6: return 64'h8000_0080;
      default: return (pc + 4) % 64'h1_0000_0000;
    endcase
  endfunction

  task automatic step(bit r, bit en, int sel, logic [31:0] ins, logic [31:0] op);
    longint exp_next;
    @(negedge clk);
    rst = r; adv_en = en; pc_sel = 3'(sel); rs_instr = ins; rs_opnd = op;
    #1;
    exp_next = model_next(sel, longint'(ins), longint'(op), m_pc, m_rs4);
    check(tag_of(sel), longint'(pc_next), exp_next);
    check("R10", longint'(opnd_zero), (op == 0) ? 1 : 0);
    @(posedge clk);
    if (r) begin
      m_pc = 64'h8000_0000; m_rs4 = 64'h8000_0000;
    end else if (en) begin
      m_rs4 = (m_pc + 4) % 64'h1_0000_0000; m_pc = exp_next;
    end
    #1;
    check(r ? "R1" : (en ? "R9" : "R8"), longint'(pc_fetch), m_pc);
    check(r ? "R1" : (en ? "R9" : "R8"), longint'(rs_pc_plus4), m_rs4);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        done = 1;
        failures++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    m_pc = 64'h8000_0000; m_rs4 = 64'h8000_0000;
    rst = 1; adv_en = 0; pc_sel = 3'd6; rs_instr = '1; rs_opnd = '1;
    // R1: reset under a stall and a vector select
    step(1, 0, 6, 32'hFFFF_FFFF, 32'h1234_5678);
    step(1, 1, 3, 32'h0, 32'h0000_1000);
    // R2: sequential steps, select 0 and 7
    step(0, 1, 0, 32'h0, 32'h5);
    step(0, 1, 7, 32'h0, 32'h5);
    step(0, 1, 0, 32'h0, 32'h0);
    // R3: branch if zero, taken with a negative offset, then not taken
    step(0, 1, 1, 32'h1000_FFFC, 32'h0);
    step(0, 1, 0, 32'h0, 32'h1);   // delay slot already fetched (R9)
    step(0, 1, 1, 32'h1000_0010, 32'h1);
    // R4: branch if non-zero, taken with a positive offset and the most negative one
    step(0, 1, 2, 32'h1400_0020, 32'hFFFF_FFFF);
    step(0, 1, 2, 32'h1400_8000, 32'h0000_0001);
    step(0, 1, 2, 32'h1400_0040, 32'h0);
    // R5: register jump through the bypassed operand
    step(0, 1, 3, 32'h0, 32'hA000_0100);
    step(0, 1, 0, 32'h0, 32'h0);
    // R6: absolute jump keeps upper bits of the register-stage address
    step(0, 1, 4, 32'h0BFF_FFFF, 32'h0);
    step(0, 1, 4, 32'h0800_0123, 32'h0);
    step(0, 1, 3, 32'h0, 32'h1FFF_FFF0);
    step(0, 1, 0, 32'h0, 32'h0);
    step(0, 1, 4, 32'h0000_0ABC, 32'h0);
    // R7: fixed vectors
    step(0, 1, 5, 32'h0, 32'h7);
    step(0, 1, 6, 32'h0, 32'h7);
    // R8: stall under every select
    for (int s = 0; s < 8; s++) step(0, 0, s, 32'h0C00_8001, (s % 2 == 0) ? 32'h0 : 32'hDEAD_BEEF);
    // R9: resume after the stall, taken branch then delay slot
    step(0, 1, 1, 32'h1000_0004, 32'h0);
    step(0, 1, 0, 32'h0, 32'h3);
    // R1: reset wins during a stall mid-run
    step(1, 0, 4, 32'h03FF_FFFF, 32'h0);
    step(0, 1, 0, 32'h0, 32'h0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule